// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block decides which clock enables a single-clock microcontroller subsystem gets. It has three modes: normal run, light idle and deep idle. Software requests an idle mode by pulsing one of two write strobes while the core is running. In light idle the processor and the watchdog lose their clock enable. The peripherals keep running, and any pending interrupt whose enable bit is set brings the core back. In deep idle only the time-base timer stays enabled. The only way back is a falling edge on one of several candidate time-base source clocks, chosen by a select input. Interrupt lines have no effect in this mode.

A falling edge on the chosen source counts only after it passes a two-flop synchronizer in the gear clock domain. On every return to run mode the block gives a one-cycle pulse on exactly one of two outputs. One tells the core to service an interrupt, which it does when the master interrupt enable is set. The other tells it to continue with the instruction after the one that requested idle. A return from deep idle also pulses a set request for the time-base interrupt latch, but only if the time-base enable was 1 when deep idle was entered. Entering and leaving deep idle never depend on that enable.

Top module: `lpm_seq`

## Requirements
- R1: After reset the block is in run mode: `cpu_ce_o`, `wdt_ce_o`, `per_ce_o` and `tbt_ce_o` are 1, and `wake_irq_o`, `wake_next_o` and `tbt_set_o` are 0.
- R2: A `req_light_i` pulse in run mode enters light idle at the next clock edge. In light idle `cpu_ce_o`=0, `wdt_ce_o`=0, `per_ce_o`=1 and `tbt_ce_o`=1.
- R3: Light idle returns to run mode at the first clock edge where some bit i has `irq_latch_i[i]` and `irq_en_i[i]` both 1. A latch bit whose enable bit is 0 has no effect.
- R4: The edge that returns the block to run mode also produces a one-cycle pulse: on `wake_irq_o` if `ime_i` was 1 at that edge, otherwise on `wake_next_o`. The two outputs are never 1 together.
- R5: A `req_deep_i` pulse in run mode enters deep idle at the next clock edge. In deep idle `cpu_ce_o`, `wdt_ce_o` and `per_ce_o` are 0 and `tbt_ce_o` is 1.
- R6: The source `tb_src_i[tb_sel_i]` passes through two synchronizer flops. A 1-to-0 transition of the selected source, set up before clock edge P1, ends deep idle at edge P3. At edge P2 the block is still in deep idle. A falling edge on a source that is not selected has no effect.
- R7: Entering and leaving deep idle do not depend on `tb_en_i`. `tbt_set_o` pulses together with the wake pulse on a return from deep idle exactly when `tb_en_i` was 1 at the entry edge. Changes to `tb_en_i` during deep idle do not matter.
- R8: If `req_light_i` and `req_deep_i` are both 1 in the same run-mode cycle, the block enters deep idle.
- R9: Request strobes that arrive in either idle mode are dropped. They are neither acted on nor kept for later, so the wake leads to run mode.
- R10: Deep idle ignores enabled pending interrupts, and light idle ignores time-base falling edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gear clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_light_i | input | 1 | Write strobe that requests light idle |
| req_deep_i | input | 1 | Write strobe that requests deep idle |
| irq_latch_i | input | NIRQ | Interrupt latch states |
| irq_en_i | input | NIRQ | Per-interrupt enable bits |
| ime_i | input | 1 | Interrupt master enable |
| tb_en_i | input | 1 | Time-base timer enable |
| tb_sel_i | input | $clog2(NSRC) | Time-base source select |
| tb_src_i | input | NSRC | Candidate time-base source clocks |
| cpu_ce_o | output | 1 | CPU clock enable |
| wdt_ce_o | output | 1 | Watchdog clock enable |
| per_ce_o | output | 1 | General peripheral clock enable |
| tbt_ce_o | output | 1 | Time-base timer clock enable |
| wake_irq_o | output | 1 | Pulse: on return to run mode, take the interrupt |
| wake_next_o | output | 1 | Pulse: on return to run mode, continue with the next instruction |
| tbt_set_o | output | 1 | Pulse that sets the time-base interrupt latch |

## Verification
The assertions check the per-cycle rules at every edge. A mode with a wake cause must leave, a mode without one must stay, the two wake pulses are exclusive and one cycle long, the latch-set pulse only comes with a wake, simultaneous requests go to deep idle, and light idle never turns into deep idle. Some behaviour can only be shown by the bench's scenarios. These are the exact three-edge synchronizer latency, the blindness to edges on sources that are not selected, the capture of the time-base enable at entry rather than at exit, and the dropping of strobes during idle. The random run compares all outputs against an independent model on every cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_LIGHT = 2'd1,
    MODE_DEEP  = 2'd2
  } mode_t;

  typedef struct packed {
    logic cpu;
    logic wdt;
    logic per;
    logic tbt;
  } ce_t;

  // Clock enable pattern that belongs to each mode
  function automatic ce_t ce_for_mode(input mode_t m);
    ce_t c;
    c.tbt = 1'b1;
    c.cpu = (m == MODE_RUN);
    c.wdt = (m == MODE_RUN);
    c.per = (m != MODE_DEEP);
    return c;
  endfunction

  // Mode derived from the two request bits; deep has precedence
  function automatic mode_t mode_from_req(input logic deep_bit, input logic light_bit);
    if (deep_bit)       return MODE_DEEP;
    else if (light_bit) return MODE_LIGHT;
    else                return MODE_RUN;
  endfunction

endpackage

// File: rtl/lpm_tb_edge.sv
module lpm_tb_edge #(
  parameter int NSRC   = 4,
  parameter int SELW   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic [SELW-1:0] sel_i,
  output logic            fall_o
);

  logic           picked;
  logic [STAGES:0] chain_q;

  // Source mux; an out-of-range select parks the line high
  always_comb begin
    picked = 1'b1;
    for (int i = 0; i < NSRC; i++) begin
      if (int'(sel_i) == i) picked = src_i[i];
    end
  end

  // Synchronizer stages plus one history flop for the edge detector
  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= picked;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/lpm_irq_scan.sv
module lpm_irq_scan #(
  parameter int NIRQ = 8
) (
  input  logic [NIRQ-1:0] latch_i,
  input  logic [NIRQ-1:0] en_i,
  output logic            pend_o
);

  function automatic logic any_armed(input logic [NIRQ-1:0] l, input logic [NIRQ-1:0] e);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NIRQ; i++) r = r | (l[i] & e[i]);
    return r;
  endfunction

  assign pend_o = any_armed(latch_i, en_i);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_light_i,
  input  logic  req_deep_i,
  input  logic  irq_pend_i,
  input  logic  tb_fall_i,
  input  logic  ime_i,
  input  logic  tb_en_i,
  output mode_t mode_o,
  output logic  wake_irq_o,
  output logic  wake_next_o,
  output logic  tbt_set_o
);

  logic  light_req_q;
  logic  deep_req_q;
  logic  tb_en_lat_q;
  logic  leave;
  mode_t mode;

  assign mode  = mode_from_req(deep_req_q, light_req_q);
  assign leave = ((mode == MODE_LIGHT) && irq_pend_i) ||
                 ((mode == MODE_DEEP)  && tb_fall_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      light_req_q <= 1'b0;
      deep_req_q  <= 1'b0;
      tb_en_lat_q <= 1'b0;
      wake_irq_o  <= 1'b0;
      wake_next_o <= 1'b0;
      tbt_set_o   <= 1'b0;
    end else begin
      wake_irq_o  <= 1'b0;
      wake_next_o <= 1'b0;
      tbt_set_o   <= 1'b0;
      if (leave) begin
        light_req_q <= 1'b0;
        deep_req_q  <= 1'b0;
        wake_irq_o  <= ime_i;
        wake_next_o <= ~ime_i;
        tbt_set_o   <= (mode == MODE_DEEP) && tb_en_lat_q;
      end else if (mode == MODE_RUN) begin
        if (req_deep_i) begin
          deep_req_q  <= 1'b1;
          tb_en_lat_q <= tb_en_i;
        end else if (req_light_i) begin
          light_req_q <= 1'b1;
        end
      end
    end
  end

  assign mode_o = mode;

endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter int NIRQ = 8,
  parameter int NSRC = 4,
  parameter int SYNC_STAGES = 2,
  localparam int SELW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_light_i,
  input  logic            req_deep_i,
  input  logic [NIRQ-1:0] irq_latch_i,
  input  logic [NIRQ-1:0] irq_en_i,
  input  logic            ime_i,
  input  logic            tb_en_i,
  input  logic [SELW-1:0] tb_sel_i,
  input  logic [NSRC-1:0] tb_src_i,
  output logic            cpu_ce_o,
  output logic            wdt_ce_o,
  output logic            per_ce_o,
  output logic            tbt_ce_o,
  output logic            wake_irq_o,
  output logic            wake_next_o,
  output logic            tbt_set_o
);

  mode_t mode_q;
  logic  irq_pend;
  logic  tb_fall;
  ce_t   ce;

  lpm_irq_scan #(.NIRQ(NIRQ)) u_scan (
    .latch_i (irq_latch_i),
    .en_i    (irq_en_i),
    .pend_o  (irq_pend)
  );

  lpm_tb_edge #(.NSRC(NSRC), .SELW(SELW), .STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (tb_src_i),
    .sel_i  (tb_sel_i),
    .fall_o (tb_fall)
  );

  lpm_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_light_i (req_light_i),
    .req_deep_i  (req_deep_i),
    .irq_pend_i  (irq_pend),
    .tb_fall_i   (tb_fall),
    .ime_i       (ime_i),
    .tb_en_i     (tb_en_i),
    .mode_o      (mode_q),
    .wake_irq_o  (wake_irq_o),
    .wake_next_o (wake_next_o),
    .tbt_set_o   (tbt_set_o)
  );

  assign ce       = ce_for_mode(mode_q);
  assign cpu_ce_o = ce.cpu;
  assign wdt_ce_o = ce.wdt;
  assign per_ce_o = ce.per;
  assign tbt_ce_o = ce.tbt;

endmodule

// File: rtl/lpm_seq_chk.sv
module lpm_seq_chk
  import lpm_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  req_light_i,
  input logic  req_deep_i,
  input mode_t mode_q,
  input logic  irq_pend,
  input logic  tb_fall,
  input logic  cpu_ce_o,
  input logic  per_ce_o,
  input logic  wake_irq_o,
  input logic  wake_next_o,
  input logic  tbt_set_o
);

  assert_light_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && req_light_i && !req_deep_i) |=> (!cpu_ce_o && per_ce_o));

  assert_light_wake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LIGHT && irq_pend) |=> (cpu_ce_o && (wake_irq_o || wake_next_o)));

  assert_wake_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wake_irq_o && wake_next_o));

  assert_wake_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq_o || wake_next_o) |=> !(wake_irq_o || wake_next_o));

  assert_deep_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DEEP && tb_fall) |=> (cpu_ce_o && per_ce_o));

  assert_tbt_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tbt_set_o |-> ((wake_irq_o || wake_next_o) && !$past(per_ce_o)));

  assert_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && req_deep_i) |=> (!per_ce_o && !cpu_ce_o));

  assert_no_light_to_deep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LIGHT) |=> (mode_q != MODE_DEEP));

  assert_deep_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DEEP && !tb_fall) |=> !per_ce_o);

  assert_light_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LIGHT && !irq_pend) |=> (!cpu_ce_o && per_ce_o));

endmodule

bind lpm_seq lpm_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_light_i (req_light_i),
  .req_deep_i  (req_deep_i),
  .mode_q      (mode_q),
  .irq_pend    (irq_pend),
  .tb_fall     (tb_fall),
  .cpu_ce_o    (cpu_ce_o),
  .per_ce_o    (per_ce_o),
  .wake_irq_o  (wake_irq_o),
  .wake_next_o (wake_next_o),
  .tbt_set_o   (tbt_set_o)
);

// File: tb/lpm_seq_bench.sv
module lpm_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_light, req_deep, ime, tb_en;
  logic [7:0] irq_latch, irq_en;
  logic [1:0] tb_sel;
  logic [3:0] tb_src;
  logic       cpu_ce, wdt_ce, per_ce, tbt_ce, wake_irq, wake_next, tbt_set;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Bench model: 0 run, 1 light, 2 deep
  int   m_mode;
  logic m_s1, m_s2, m_s3, m_lat, m_wi, m_wn, m_ts;

  always #2.5 clk = ~clk;

  lpm_seq u_lpm_seq (
    .clk(clk), .rst_n(rst_n), .req_light_i(req_light), .req_deep_i(req_deep),
    .irq_latch_i(irq_latch), .irq_en_i(irq_en), .ime_i(ime), .tb_en_i(tb_en),
    .tb_sel_i(tb_sel), .tb_src_i(tb_src), .cpu_ce_o(cpu_ce), .wdt_ce_o(wdt_ce),
    .per_ce_o(per_ce), .tbt_ce_o(tbt_ce), .wake_irq_o(wake_irq),
    .wake_next_o(wake_next), .tbt_set_o(tbt_set)
  );

  function automatic logic [3:0] ce_exp(input int m);
    case (m)
      1:       return 4'b0011;
      2:       return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [6:0] obs();
    return {cpu_ce, wdt_ce, per_ce, tbt_ce, wake_irq, wake_next, tbt_set};
  endfunction

  task automatic chk(input string req, input logic [6:0] exp);
    checks++;
    if (obs() !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, obs(), exp, $time);
    end
  endtask

  task automatic model_step();
    logic pend, fall;
    int   nm;
    pend = |(irq_latch & irq_en);
    fall = m_s3 & ~m_s2;
    nm = m_mode; m_wi = 0; m_wn = 0; m_ts = 0;
    if (!rst_n) begin
      nm = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_lat = 0;
    end else begin
      if (m_mode == 0) begin
        if (req_deep) begin nm = 2; m_lat = tb_en; end
        else if (req_light) nm = 1;
      end else if ((m_mode == 1 && pend) || (m_mode == 2 && fall)) begin
        m_ts = (m_mode == 2) && m_lat;
        nm = 0; m_wi = ime; m_wn = ~ime;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = tb_src[tb_sel];
    end
    m_mode = nm;
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      model_step();
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; req_light = 0; req_deep = 0; ime = 0; tb_en = 0;
    irq_latch = 0; irq_en = 0; tb_sel = 0; tb_src = 4'hF;
    m_mode = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0; m_lat = 0;
    tick(3);
    chk("R1 in reset", {4'b1111, 3'b000});
    rst_n = 1;
    tick(4);
    chk("R1 after release", {4'b1111, 3'b000});

    // Light idle
    req_light = 1; tick(); req_light = 0;
    chk("R2 light entry", {4'b0011, 3'b000});
    irq_latch = 8'h01; irq_en = 8'h02; tb_src[0] = 0; req_deep = 1;
    tick(); req_deep = 0; tick(4);
    chk("R3 R9 R10 light holds", {4'b0011, 3'b000});
    tb_src[0] = 1; tick(3);
    ime = 1; irq_en = 8'h03; tick();
    chk("R3 R4 light wake irq", {4'b1111, 3'b100});
    irq_latch = 0; irq_en = 0; tick();
    chk("R4 pulse one cycle", {4'b1111, 3'b000});

    // Deep idle with time-base enable set at entry
    tb_en = 1; ime = 0; req_deep = 1; tick(); req_deep = 0;
    chk("R5 deep entry", {4'b0001, 3'b000});
    tb_en = 0; irq_latch = 8'hFF; irq_en = 8'hFF; req_light = 1;
    tick(); req_light = 0; tick(3);
    chk("R9 R10 deep holds", {4'b0001, 3'b000});
    irq_latch = 0; irq_en = 0;
    tb_src[1] = 0; tick(4);
    chk("R6 unselected fall ignored", {4'b0001, 3'b000});
    tb_src[1] = 1; tick(3);
    tb_src[0] = 0; tick(2);
    chk("R6 still deep at P2", {4'b0001, 3'b000});
    tick();
    chk("R6 R7 wake at P3", {4'b1111, 3'b011});
    tick();
    chk("R7 set pulse one cycle", {4'b1111, 3'b000});
    tb_src[0] = 1; tick(3);

    // Deep idle with enable clear at entry, set during idle
    tb_sel = 2; tb_en = 0; ime = 1; req_deep = 1; tick(); req_deep = 0;
    tb_en = 1; tb_src[2] = 0; tick(3);
    chk("R7 no set when enable clear at entry", {4'b1111, 3'b100});
    tb_src[2] = 1; tb_en = 0; tick(3);

    // Simultaneous requests
    req_light = 1; req_deep = 1; tick(); req_light = 0; req_deep = 0;
    chk("R8 deep wins", {4'b0001, 3'b000});
    tb_src[2] = 0; tick(3);
    chk("R8 R4 wake from deep", {4'b1111, 3'b100});
    tb_src[2] = 1; tick(3);

    // Random phase against the bench model
    for (int k = 0; k < 4000; k++) begin
      req_light = ($urandom % 8) == 0;
      req_deep  = ($urandom % 14) == 0;
      irq_latch = 8'($urandom & $urandom & $urandom);
      irq_en    = 8'($urandom);
      if (($urandom % 4) != 0) irq_latch = 0;
      ime   = 1'($urandom);
      tb_en = 1'($urandom);
      if (($urandom % 60) == 0) tb_sel = 2'($urandom);
      for (int b = 0; b < 4; b++) if (($urandom % 6) == 0) tb_src[b] = ~tb_src[b];
      tick();
      chk("R2 R3 R4 R5 R6 R7 R8 R9 R10 random", {ce_exp(m_mode), m_wi, m_wn, m_ts});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule